// File: doc/BRIEF.md
# Low Duty-Cycle Receiver Scheduler

This block switches a receiver on and off to reduce average power while it listens for traffic. A 16-bit command word sets a 7-bit on-time value D and an enable bit. The cycle length comes from the same multiplier M and exponent R that drive the wake-up timer, counted in the same base tick. Each cycle is M·2^R ticks long. The receiver is enabled at the start of the cycle. It is turned off again after (2D+1)·2^R ticks, unless the signal-quality input is holding it on. The resulting duty cycle is (2D+1)/M.

When the demodulator reports valid data, the block raises a one-cycle interrupt and keeps the receiver running. Reception continues while signal quality stays good. After that the block waits until the host has emptied the FIFO and cleared every other pending interrupt, and only then returns to low power. The command write and all status inputs are plain level or strobe signals. There is no streaming payload, so there is no valid/ready handshake and no back-pressure.

Top module: `ldc_rx_sched`

## Requirements
- R1: A write (`cmd_wr` high for one clock) updates the settings only when `cmd_data[15:8]` equals 8'hC8. Bit 0 is the enable and bits 7..1 are D. A write with any other upper byte leaves the outputs unchanged.
- R2: After reset D is 7 and the enable is 0. Both `rx_enable` and `data_irq` are low, and they stay low until an enabling write arrives.
- R3: The cycle counter advances on each clock where `tick` is high. Every M·2^R ticks it completes a period, and that clears it. It is also cleared by any accepted write. With the enable set and the block asleep, `rx_enable` rises on the clock edge that samples the tick completing the period.
- R4: The listen window is (2D+1)·2^R ticks, measured from the start of the cycle. While listening, if the tick count reaches the window and `dqd` is low with no valid data, `rx_enable` falls on the next edge.
- R5: While listening, `dqd` high holds `rx_enable` on past the end of the window.
- R6: `valid_data` high while listening moves the block to receive. `data_irq` goes high for exactly one clock, on the same edge, and `rx_enable` stays high.
- R7: In receive the block stays on while `dqd` is high. When `dqd` is low it moves to a drain phase and keeps `rx_enable` high. It goes to sleep only on an edge where `fifo_empty` is 1 and `irq_pending` is 0.
- R8: If 2D+1 ≥ M (this includes M = 0), the enabled receiver stays on without pause.
- R9: Clearing the enable while listening drops `rx_enable` on the next edge. Clearing it during receive or drain has no effect until the drain phase completes, and no new cycle starts after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word |
| wake_m | input | 8 | Period multiplier M |
| wake_r | input | 5 | Period exponent R |
| tick | input | 1 | Base time tick, one clock wide |
| dqd | input | 1 | Data-quality indication |
| valid_data | input | 1 | Valid frame detected |
| fifo_empty | input | 1 | Receive FIFO fully read |
| irq_pending | input | 1 | Other interrupts still pending |
| rx_enable | output | 1 | Receiver power enable |
| data_irq | output | 1 | One-clock valid-data interrupt |

## Verification
A wrong cycle counter shows up within one period: `rx_enable` rises early or late, or the on-time has the wrong length. A stuck state register shows up as `rx_enable` held high through sleep, or dropped while the FIFO still holds data. That discrepancy appears at the first edge where the reference model and the design disagree. A wrong interrupt state shows up as a missing, repeated or doubled `data_irq` in the cycle right after `valid_data`.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_LISTEN  = 2'd1,
    ST_RECEIVE = 2'd2,
    ST_DRAIN   = 2'd3
  } ldc_state_e;

  localparam logic [7:0] CMD_HDR   = 8'hC8;
  localparam logic [7:0] CMD_RESET = 8'h0E;
endpackage

// File: rtl/ldc_cmd_reg.sv
module ldc_cmd_reg #(
  parameter int D_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [15:0]    wdata,
  output logic [D_W-1:0] d_par,
  output logic           en,
  output logic           hit
);
  import ldc_pkg::*;

  assign hit = wr && (wdata[15:8] == CMD_HDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_par <= CMD_RESET[D_W:1];
      en    <= CMD_RESET[0];
    end else if (hit) begin
      d_par <= wdata[D_W:1];
      en    <= wdata[0];
    end
  end

  // R1: a write with a foreign header leaves settings untouched
  p_foreign_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[15:8] != CMD_HDR) |=> $stable({d_par, en}));
endmodule

// File: rtl/ldc_cycle_timer.sv
module ldc_cycle_timer #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] pos,
  output logic             cycle_start
);
  logic at_end;

  assign at_end      = (period != '0) && (pos >= period - 1'b1);
  assign cycle_start = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (clr)
      pos <= '0;
    else if (tick) begin
      if (at_end || period == '0)
        pos <= '0;
      else
        pos <= pos + 1'b1;
    end
  end

  // R3: the count moves only on ticks or clears
  p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(pos));
endmodule

// File: rtl/ldc_sched_fsm.sv
module ldc_sched_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic always_on,
  input  logic expired,
  input  logic cycle_start,
  input  logic dqd,
  input  logic valid_data,
  input  logic fifo_empty,
  input  logic irq_pending,
  output logic rx_enable,
  output logic data_irq
);
  import ldc_pkg::*;

  ldc_state_e state, nxt;
  logic       irq_set;

  always_comb begin
    nxt     = state;
    irq_set = 1'b0;
    unique case (state)
      ST_SLEEP:
        if (en && (cycle_start || always_on)) nxt = ST_LISTEN;
      ST_LISTEN:
        if (!en)
          nxt = ST_SLEEP;
        else if (valid_data) begin
          nxt     = ST_RECEIVE;
          irq_set = 1'b1;
        end else if (!always_on && !dqd && expired)
          nxt = ST_SLEEP;
      ST_RECEIVE:
        if (!dqd) nxt = ST_DRAIN;
      ST_DRAIN:
        if (fifo_empty && !irq_pending) nxt = ST_SLEEP;
      default: nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SLEEP;
      data_irq <= 1'b0;
    end else begin
      state    <= nxt;
      data_irq <= irq_set;
    end
  end

  assign rx_enable = (state != ST_SLEEP);

  // R6: valid data while listening gives one interrupt and receive
  p_irq_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LISTEN && en && valid_data) |=> (data_irq && state == ST_RECEIVE));
  // R6: interrupt lasts one clock
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_irq |=> !data_irq);
  // R7: drain holds while FIFO or interrupts are outstanding
  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !(fifo_empty && !irq_pending)) |=> state == ST_DRAIN);
  // R5: good quality keeps the receiver on while listening
  p_listen_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LISTEN && en && dqd) |=> rx_enable);
  // R9: disabling while listening forces sleep
  p_disable_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LISTEN && !en) |=> !rx_enable);
endmodule

// File: rtl/ldc_rx_sched.sv
module ldc_rx_sched #(
  parameter int M_W = 8,
  parameter int R_W = 5,
  parameter int D_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [15:0]    cmd_data,
  input  logic [M_W-1:0] wake_m,
  input  logic [R_W-1:0] wake_r,
  input  logic           tick,
  input  logic           dqd,
  input  logic           valid_data,
  input  logic           fifo_empty,
  input  logic           irq_pending,
  output logic           rx_enable,
  output logic           data_irq
);
  localparam int SHIFT_MAX = (1 << R_W) - 1;
  localparam int BASE_W    = (M_W > D_W + 1) ? M_W : D_W + 1;
  localparam int CNT_W     = BASE_W + SHIFT_MAX + 1;

  logic [D_W-1:0]   d_par;
  logic             en, hit;
  logic [CNT_W-1:0] m_ext, odd_ext, period, win_len, pos;
  logic             cycle_start, always_on, expired;

  ldc_cmd_reg #(.D_W(D_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_data),
    .d_par(d_par), .en(en), .hit(hit)
  );

  assign m_ext     = {{(CNT_W-M_W){1'b0}}, wake_m};
  assign odd_ext   = {{(CNT_W-D_W-1){1'b0}}, d_par, 1'b1};
  assign period    = m_ext << wake_r;
  assign win_len   = odd_ext << wake_r;
  assign always_on = (odd_ext >= m_ext);
  assign expired   = (pos >= win_len);

  ldc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(hit),
    .period(period), .pos(pos), .cycle_start(cycle_start)
  );

  ldc_sched_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .always_on(always_on),
    .expired(expired), .cycle_start(cycle_start), .dqd(dqd),
    .valid_data(valid_data), .fifo_empty(fifo_empty),
    .irq_pending(irq_pending), .rx_enable(rx_enable), .data_irq(data_irq)
  );
endmodule

// File: tb/ldc_rx_sched_bench.sv
module ldc_rx_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0] wake_m = 8'd8;
  logic [4:0] wake_r = 5'd1;
  logic tick = 1'b0;
  logic dqd = 1'b0, valid_data = 1'b0, fifo_empty = 1'b1, irq_pending = 1'b0;
  logic rx_enable, data_irq;

  int tests = 0, fails = 0;
  string cur_req = "R2";
  bit running = 1'b0;
  bit finished = 1'b0;
  int tick_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldc_rx_sched u_ldc_rx_sched (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .wake_m(wake_m), .wake_r(wake_r), .tick(tick), .dqd(dqd),
    .valid_data(valid_data), .fifo_empty(fifo_empty),
    .irq_pending(irq_pending), .rx_enable(rx_enable), .data_irq(data_irq)
  );

  // behavioural reference: 0 sleep, 1 listen, 2 receive, 3 drain
  int     ms = 0;
  longint mpos = 0;
  int     md = 7;
  bit     men = 0, mirq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mpos = 0; md = 7; men = 0; mirq = 0;
    end else begin
      longint per, win;
      bit alw, cs, expd, acc;
      int ns;
      bit nirq;
      per  = longint'(wake_m) << wake_r;
      win  = longint'(2*md + 1) << wake_r;
      alw  = (2*md + 1) >= int'(wake_m);
      cs   = tick && per != 0 && mpos >= per - 1;
      expd = mpos >= win;
      ns = ms; nirq = 0;
      case (ms)
        0: if (men && (cs || alw)) ns = 1;
        1: if (!men) ns = 0;
           else if (valid_data) begin ns = 2; nirq = 1; end
           else if (!alw && !dqd && expd) ns = 0;
        2: if (!dqd) ns = 3;
        default: if (fifo_empty && !irq_pending) ns = 0;
      endcase
      acc = cmd_wr && cmd_data[15:8] == 8'hC8;
      if (acc) mpos = 0;
      else if (tick) mpos = (cs || per == 0) ? 0 : mpos + 1;
      if (acc) begin md = int'(cmd_data[7:1]); men = cmd_data[0]; end
      ms = ns; mirq = nirq;
    end
  end

  always @(negedge clk) begin
    if (running && !finished) begin
      tests++;
      if (rx_enable !== (ms != 0) || data_irq !== mirq) begin
        fails++;
        $display("FAIL %s: rx_enable=%0b data_irq=%0b expected rx_enable=%0b data_irq=%0b",
                 cur_req, rx_enable, data_irq, (ms != 0), mirq);
      end
    end
  end

  // tick on every other clock
  always @(negedge clk) begin
    tick_div <= tick_div + 1;
    tick     <= (tick_div % 2 == 0);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [15:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_rx_rise();
    for (int i = 0; i < 400 && !rx_enable; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tests++;
    if (rx_enable !== 1'b0 || data_irq !== 1'b0) begin
      fails++;
      $display("FAIL R2: rx_enable=%0b data_irq=%0b expected 0 0", rx_enable, data_irq);
    end
    running = 1'b1;
    cur_req = "R2"; run(80);                 // disabled at reset
    cur_req = "R1"; write_cmd(16'h1203);     // foreign header ignored
    run(80);
    cur_req = "R3"; write_cmd(16'hC803);     // D=1 en=1, M=8 R=1
    run(200);
    cur_req = "R4"; run(60);
    cur_req = "R5"; wait_rx_rise(); dqd = 1'b1; run(50); dqd = 1'b0; run(80);
    cur_req = "R6"; wait_rx_rise(); run(3);
    valid_data = 1'b1; dqd = 1'b1; fifo_empty = 1'b0; irq_pending = 1'b1;
    run(1); valid_data = 1'b0; run(20);
    cur_req = "R7"; dqd = 1'b0; run(12); fifo_empty = 1'b1; run(6);
    irq_pending = 1'b0; run(40);
    cur_req = "R9"; wait_rx_rise(); run(2); write_cmd(16'hC802); run(60);
    write_cmd(16'hC803); wait_rx_rise();
    valid_data = 1'b1; dqd = 1'b1; fifo_empty = 1'b0;
    run(1); valid_data = 1'b0;
    write_cmd(16'hC802); run(15); dqd = 1'b0; run(10);
    fifo_empty = 1'b1; run(100);
    cur_req = "R8"; write_cmd(16'hC809); run(80);
    wake_m = 8'd0; run(30);
    cur_req = "R3"; wake_m = 8'd3; wake_r = 5'd2; write_cmd(16'hC801); run(200);
    cur_req = "R4"; dqd = 1'b1; run(7); dqd = 1'b0; run(120);
    running = 1'b0;
    summary();
  end
endmodule